// File: doc/BRIEF.md
# Binary Paper-Tape Bootstrap Loader

This block brings a processor up from paper tape before any program sits in memory. Once the operator presses the load control, the block takes 8-hole tape lines from the reader. A line counts only when its marker hole (hole 8) is punched. Three counted lines are packed into one 18-bit word, six bits per line. The first word is a loader command, the second is data, the third is a command again, and the pattern continues. A deposit command names a 12-bit address, and the data word after it is written there through a single-cycle memory write port. A jump command ends loading and raises a one-clock run request that carries the start address. A command word that is neither deposit nor jump sets a sticky error flag, and loading halts without touching memory.

The controller is a four-state machine. `S_IDLE` waits for the load control. `S_CMD` expects a command word. `S_DATA` expects the data word for a pending deposit. `S_FAULT` holds after a bad command. The transitions are as follows:
- start moves any state to `S_CMD`.
- In `S_CMD`, a deposit word moves to `S_DATA`, a jump word moves to `S_IDLE`, and any other word moves to `S_FAULT`.
- In `S_DATA`, a completed word moves back to `S_CMD`.
- `S_IDLE` and `S_FAULT` leave only on start.

Top module: `tape_boot_loader`

## Requirements
- R1: After reset, `mem_we`, `run_req` and `load_err` are 0, `busy` is 0, and tape lines have no effect until `start` is pulsed.
- R2: A line with hole 8 (`line_holes[7]`) clear is discarded entirely and does not advance word assembly.
- R3: Hole 7 (`line_holes[6]`) is ignored. `line_holes[5:0]` (hole 6 down to hole 1) supply six bits. The first counted line of a word fills word[17:12], the second fills word[11:6] and the third fills word[5:0]. Word bit 0 in tape numbering is word[17].
- R4: The first word after `start` is a command. Words then alternate data/command for as long as deposits continue.
- R5: A command whose opcode field word[17:13] equals 5'b01101 is a deposit. The data word that follows is written to address word[11:0] of the command, with `mem_we` high for exactly one clock. `mem_we` rises on the clock edge that captures the data word's third counted line.
- R6: A command with opcode 5'b11000 is a jump. `run_req` pulses for one clock, on the edge that captures the command's third line, with `run_addr` equal to word[11:0]. `run_addr` is held until a later jump. No further writes occur until the next `start`.
- R7: Any other opcode in a command position sets `load_err`. The flag stays set and no write occurs until `start` clears it.
- R8: `start` discards any partially assembled word and restarts with a command word.
- R9: Word bit 5 of a command (word[12], the indirection bit) does not affect command decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load control pulse; begins or restarts loading |
| line_valid | input | 1 | Strobe: `line_holes` carries a tape line this cycle |
| line_holes | input | 8 | Hole pattern, bit 0 = hole 1 ... bit 7 = hole 8 |
| mem_we | output | 1 | One-clock memory write enable |
| mem_addr | output | 12 | Write address |
| mem_wdata | output | 18 | Write data |
| run_req | output | 1 | One-clock request to begin execution |
| run_addr | output | 12 | Execution start address |
| load_err | output | 1 | Sticky bad-command flag |
| busy | output | 1 | High while in `S_CMD` or `S_DATA` |

## Verification
The bench sweeps every 5-bit opcode value in a command position, with and without the indirection bit. A loose decoder would accept a stray opcode as deposit or jump, or would misread the indirection bit, and the sweep exposes either fault. A long run of deposits mixes lines that lack hole 8 and lines with hole 7 punched. A design that counted the unmarked lines or kept hole 7 would write shifted or corrupted words to the wrong addresses. Further checks confirm that a jump or a bad command freezes the write port, that the error flag persists until the next start, and that a restart in the middle of a word discards the partial lines. A design that failed on these points would write memory after loading had ended or would misalign every word that followed.

// File: rtl/tape_loader_pkg.sv
package tape_loader_pkg;
    localparam int WORD_W    = 18;
    localparam int ADDR_W    = 12;
    localparam int LINE_W    = 8;
    localparam int LINES_PW  = 3;
    localparam int SEXT_W    = WORD_W / LINES_PW;
    localparam int OPC_W     = 5;
    localparam int MARK_HOLE = LINE_W - 1;

    localparam logic [OPC_W-1:0] OPC_DEPOSIT = 5'b01101;
    localparam logic [OPC_W-1:0] OPC_JUMP    = 5'b11000;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CMD   = 2'd1,
        S_DATA  = 2'd2,
        S_FAULT = 2'd3
    } load_state_t;
endpackage

// File: rtl/tape_word_assembler.sv
module tape_word_assembler
    import tape_loader_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              enable,
    input  logic              line_valid,
    input  logic [LINE_W-1:0] line_holes,
    output logic              word_ok,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(LINES_PW);

    logic [CNT_W-1:0]  count_q;
    logic [SEXT_W-1:0] sext_q [LINES_PW-1];
    logic              accept;
    logic              last_line;

    assign accept    = enable && line_valid && line_holes[MARK_HOLE] && !clear;
    assign last_line = (count_q == CNT_W'(LINES_PW - 1));
    assign word_ok   = accept && last_line;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (accept) begin
            count_q <= last_line ? '0 : count_q + 1'b1;
        end
    end

    for (genvar g = 0; g < LINES_PW - 1; g++) begin : g_sext
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sext_q[g] <= '0;
            end else if (accept && count_q == CNT_W'(g)) begin
                sext_q[g] <= line_holes[SEXT_W-1:0];
            end
        end
        assign word[WORD_W-1-g*SEXT_W -: SEXT_W] = sext_q[g];
    end
    assign word[SEXT_W-1:0] = line_holes[SEXT_W-1:0];

    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q < CNT_W'(LINES_PW));

    // R2
    unmarked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !line_holes[MARK_HOLE] && !clear) |=> $stable(count_q));
endmodule

// File: rtl/loader_cmd_decode.sv
module loader_cmd_decode
    import tape_loader_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              is_deposit,
    output logic              is_jump,
    output logic [ADDR_W-1:0] target
);
    logic [OPC_W-1:0] opc;

    assign opc        = word[WORD_W-1 -: OPC_W];
    assign is_deposit = (opc == OPC_DEPOSIT);
    assign is_jump    = (opc == OPC_JUMP);
    assign target     = word[ADDR_W-1:0];
endmodule

// File: rtl/tape_boot_loader.sv
module tape_boot_loader
    import tape_loader_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              line_valid,
    input  logic [7:0]        line_holes,
    output logic              mem_we,
    output logic [11:0]       mem_addr,
    output logic [17:0]       mem_wdata,
    output logic              run_req,
    output logic [11:0]       run_addr,
    output logic              load_err,
    output logic              busy
);
    load_state_t       state_q, state_d;
    logic              word_ok;
    logic [WORD_W-1:0] word;
    logic              is_deposit, is_jump;
    logic [ADDR_W-1:0] target;
    logic              active;

    assign active = (state_q == S_CMD) || (state_q == S_DATA);
    assign busy   = active;

    tape_word_assembler asm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start),
        .enable     (active),
        .line_valid (line_valid),
        .line_holes (line_holes),
        .word_ok    (word_ok),
        .word       (word)
    );

    loader_cmd_decode dec_i (
        .word       (word),
        .is_deposit (is_deposit),
        .is_jump    (is_jump),
        .target     (target)
    );

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = S_CMD;
        end else begin
            unique case (state_q)
                S_IDLE:  state_d = S_IDLE;
                S_FAULT: state_d = S_FAULT;
                S_CMD: begin
                    if (word_ok) begin
                        if (is_deposit)   state_d = S_DATA;
                        else if (is_jump) state_d = S_IDLE;
                        else              state_d = S_FAULT;
                    end
                end
                S_DATA: if (word_ok) state_d = S_CMD;
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            run_req   <= 1'b0;
            run_addr  <= '0;
            load_err  <= 1'b0;
        end else begin
            mem_we  <= 1'b0;
            run_req <= 1'b0;
            if (start) begin
                load_err <= 1'b0;
            end else if (word_ok && state_q == S_CMD) begin
                if (is_deposit) begin
                    mem_addr <= target;
                end else if (is_jump) begin
                    run_req  <= 1'b1;
                    run_addr <= target;
                end else begin
                    load_err <= 1'b1;
                end
            end else if (word_ok && state_q == S_DATA) begin
                mem_we    <= 1'b1;
                mem_wdata <= word;
            end
        end
    end

    // R5
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R5
    we_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (state_q == S_CMD || $past(start)));

    // R6
    run_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_req |=> !run_req);

    // R6
    run_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_req && !start) |-> state_q == S_IDLE);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_err && !start) |=> load_err);

    // R7
    err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_err && !$past(start)) |-> !mem_we);
endmodule

// File: tb/tape_boot_loader_tb.sv
module tape_boot_loader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        line_valid = 1'b0;
    logic [7:0]  line_holes = '0;
    logic        mem_we, run_req, load_err, busy;
    logic [11:0] mem_addr, run_addr;
    logic [17:0] mem_wdata;

    int checks = 0;
    int fails  = 0;
    int wr_count = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tape_boot_loader dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .line_valid(line_valid), .line_holes(line_holes),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .run_req(run_req), .run_addr(run_addr),
        .load_err(load_err), .busy(busy)
    );

    always @(negedge clk) if (rst_n && mem_we) wr_count++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_line(input logic [7:0] h);
        line_valid = 1'b1;
        line_holes = h;
        @(negedge clk);
        line_valid = 1'b0;
        line_holes = '0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_word(input logic [17:0] w, input logic noisy, input logic h7);
        for (int k = 0; k < 3; k++) begin
            if (noisy) send_line({1'b0, 1'b1, 6'(k * 21 + 5)});
            send_line({1'b1, h7, w[17 - 6*k -: 6]});
        end
    endtask

    function automatic logic [17:0] mk_cmd(input logic [4:0] op, input logic ind, input logic [11:0] a);
        return {op, ind, a};
    endfunction

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        int base;
        logic [17:0] d;
        logic [11:0] a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and lines ignored before start
        chk("R1 mem_we", 32'(mem_we), 0);
        chk("R1 run_req", 32'(run_req), 0);
        chk("R1 load_err", 32'(load_err), 0);
        chk("R1 busy", 32'(busy), 0);
        send_word(mk_cmd(5'b01101, 0, 12'h123), 0, 0);
        send_word(18'h2AAAA, 0, 0);
        chk("R1 no write before start", 32'(wr_count), 0);

        // R2 R3 R4 R5 R9: deposit sweep with noise and hole 7
        pulse_start();
        chk("R4 busy after start", 32'(busy), 1);
        for (int i = 0; i < 64; i++) begin
            a = 12'((i * 67 + 3) % 4096);
            d = 18'((i * 4111 + 7) % 262144);
            base = wr_count;
            send_word(mk_cmd(5'b01101, 1'(i % 2), a), 1'(i % 3 == 0), 1'(i % 2));
            chk("R4 no write on command", 32'(wr_count - base), 0);
            send_word(d, 1'(i % 4 == 1), 1'(i % 5 == 2));
            chk("R5 write strobe", 32'(mem_we), 1);
            chk("R5 write address", 32'(mem_addr), 32'(a));
            chk("R3 write data", 32'(mem_wdata), 32'(d));
            @(negedge clk);
            chk("R5 one clock strobe", 32'(mem_we), 0);
        end
        chk("R2 write count", 32'(wr_count), 64);

        // R6: jump
        send_word(mk_cmd(5'b11000, 1, 12'o7301), 1, 1);
        chk("R6 run_req", 32'(run_req), 1);
        chk("R6 run_addr", 32'(run_addr), 32'(12'o7301));
        @(negedge clk);
        chk("R6 run pulse width", 32'(run_req), 0);
        chk("R6 run_addr held", 32'(run_addr), 32'(12'o7301));
        chk("R6 idle after jump", 32'(busy), 0);
        base = wr_count;
        send_word(mk_cmd(5'b01101, 0, 12'h010), 0, 0);
        send_word(18'h15555, 0, 0);
        chk("R6 no write after jump", 32'(wr_count - base), 0);

        // R7: bad command, stickiness, clear by start
        pulse_start();
        send_word(mk_cmd(5'b00001, 0, 12'h040), 0, 0);
        chk("R7 err set", 32'(load_err), 1);
        base = wr_count;
        send_word(18'h3FFFF, 0, 0);
        send_word(mk_cmd(5'b01101, 0, 12'h041), 0, 0);
        send_word(18'h00001, 0, 0);
        chk("R7 no write after error", 32'(wr_count - base), 0);
        chk("R7 err sticky", 32'(load_err), 1);
        pulse_start();
        chk("R7 err cleared by start", 32'(load_err), 0);

        // R8: restart discards partial word
        send_line({2'b10, 6'o77});
        send_line({2'b10, 6'o12});
        pulse_start();
        send_word(mk_cmd(5'b01101, 0, 12'o4444), 0, 0);
        send_word(18'o123456, 0, 0);
        chk("R8 write after restart", 32'(mem_we), 1);
        chk("R8 address after restart", 32'(mem_addr), 32'(12'o4444));
        chk("R8 data after restart", 32'(mem_wdata), 32'(18'o123456));

        // R9 R7 R6: opcode sweep
        for (int op = 0; op < 32; op++) begin
            for (int ind = 0; ind < 2; ind++) begin
                pulse_start();
                send_word(mk_cmd(5'(op), 1'(ind), 12'(op * 100 + ind)), 0, 0);
                chk("R9 err for opcode", 32'(load_err),
                    32'((op != 13 && op != 24) ? 1 : 0));
                chk("R9 jump for opcode", 32'(run_req), 32'((op == 24) ? 1 : 0));
                chk("R9 busy for opcode", 32'(busy), 32'((op == 13) ? 1 : 0));
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule